// File: doc/BRIEF.md
# Checkerboard Bitline Crosstalk Self-Test Controller

This block is a self-test sequencer for a bit-wide memory array that is addressed by row and column. It looks for disturbance between neighbouring columns. For each of two polarities, it first fills the whole array with an alternating pattern, so that every cell holds the opposite value from the cells on either side of it. It then takes each column in turn as the victim. In every row of that victim, it repeatedly flips the cells of the adjacent columns to their inverse and back, without ever writing the victim. After that it reads the victim cell and compares it with the value the pattern says it should hold.

A single start pulse launches the run. The block drives the memory's row, column, write data, write enable and read enable from registers. It takes the read data back one cycle after a read is placed on the pins. When the run ends it raises done. It raises fail and keeps the row and column of the first cell that read back wrong. A stop-on-fail input decides whether the run ends at that first mismatch or goes on through both polarities.

Top module: `cbx_xtalk_bist`

## Requirements
- R1: After reset, done, fail, mem_we and mem_re are low. A start pulse sampled in the idle state begins a run. The first write appears on the pins one cycle after the edge that sampled start: row 0, column 0, data 0. No access is issued while idle.
- R2: Each polarity begins by writing every cell once, row by row with the column advancing fastest. The value written is row[0] XOR column[0] XOR polarity. Polarity 0 runs first and polarity 1 second.
- R3: Victim columns are taken in ascending order, and within a column the rows are taken in ascending order. For each victim cell, the controller makes TOGGLES repetitions. Each repetition writes the left neighbour with its inverted pattern value and then its pattern value, then does the same for the right neighbour. The victim column is never written in this phase.
- R4: Column 0 is disturbed only through column 1, and column COLS-1 only through column COLS-2. Each edge victim therefore gets half the neighbour writes of an interior victim.
- R5: After the neighbour writes, the controller issues one read of the victim cell (mem_re high, mem_we low). The data returned on the next cycle is compared with the victim's pattern value. mem_we and mem_re are never high together.
- R6: On a mismatch, fail goes high. fail_row and fail_col take the address of the first mismatching cell of the run, and later mismatches leave them unchanged.
- R7: With stop_on_fail high, the run ends at the first mismatch. done rises and no further memory access is issued.
- R8: With stop_on_fail low, the run always finishes the full sequence of both polarities, whatever mismatches occur.
- R9: done rises after the compare of the last victim cell of polarity 1 and stays high until the next start. On a fault-free memory, fail stays low.
- R10: A new start clears done, fail and the captured address on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when sampled in idle |
| stop_on_fail | input | 1 | End the run at the first mismatch |
| mem_row | output | RW | Memory row address |
| mem_col | output | CW | Memory column address |
| mem_wdata | output | 1 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 1 | Memory read data, valid one cycle after mem_re |
| done | output | 1 | Run finished |
| fail | output | 1 | At least one mismatch seen |
| fail_row | output | RW | Row of the first mismatch |
| fail_col | output | CW | Column of the first mismatch |

## Verification
Every command is registered. Each write therefore sits on the pins for exactly one cycle, and consecutive writes come back to back. A read occupies three controller cycles: the read is issued, the memory returns data one cycle later, and the compare happens in the third cycle. fail and done change one cycle after that compare.

The bench samples at falling edges and checks each access in the order it appears against a reference sequence it builds itself. It checks the first write on the second falling edge after start is driven, and the fail address and access count once done is seen. Its memory model places coupling faults in which an upward write to a neighbour forces the victim to 1. Such a fault can only show in the polarity where the victim holds 0, so the bench derives the expected stop point from that polarity.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BG,
    ST_INV,
    ST_RST,
    ST_RDI,
    ST_RDW,
    ST_CMP
  } cbx_state_e;

  // Alternating background value for a cell in a given polarity.
  function automatic logic bg_bit(input logic row0, input logic col0, input logic pol);
    return row0 ^ col0 ^ pol;
  endfunction

endpackage

// File: rtl/cbx_step_ctr.sv
module cbx_step_ctr #(
  parameter int LIMIT = 8,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         last
);

  assign last = (q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (inc) begin
      q <= last ? '0 : q + W'(1);
    end
  end

  // Counter never leaves its range (addresses stay inside the array).
  assert_ctr_range_R3: assert property (@(posedge clk) disable iff (rst)
    int'(q) <= LIMIT - 1);

endmodule

// File: rtl/cbx_fail_log.sv
module cbx_fail_log #(
  parameter int RW = 3,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hit,
  input  logic [RW-1:0] hit_row,
  input  logic [CW-1:0] hit_col,
  output logic          fail,
  output logic [RW-1:0] fail_row,
  output logic [CW-1:0] fail_col
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail     <= 1'b0;
      fail_row <= '0;
      fail_col <= '0;
    end else if (hit && !fail) begin
      fail     <= 1'b1;
      fail_row <= hit_row;
      fail_col <= hit_col;
    end
  end

  // First failing address is held until the next run clears it.
  assert_first_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> (fail && $stable(fail_row) && $stable(fail_col)));

  assert_hit_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr) |=> fail);

endmodule

// File: rtl/cbx_xtalk_bist.sv
module cbx_xtalk_bist #(
  parameter int ROWS    = 8,
  parameter int COLS    = 8,
  parameter int TOGGLES = 2,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop_on_fail,
  output logic [RW-1:0] mem_row,
  output logic [CW-1:0] mem_col,
  output logic          mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic          mem_rdata,
  output logic          done,
  output logic          fail,
  output logic [RW-1:0] fail_row,
  output logic [CW-1:0] fail_col
);
  import cbx_pkg::*;

  localparam int TW  = (TOGGLES > 1) ? $clog2(TOGGLES) : 1;
  localparam int CWX = CW + 1;

  cbx_state_e    state;
  logic          pol;
  logic          side;     // 0: left neighbour, 1: right neighbour
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [TW-1:0] tog_q;
  logic          row_last, col_last, tog_last;
  logic          ctr_clr, row_inc, col_inc, tog_inc;
  logic          has_right, has_left;
  logic [CW-1:0] agg_col;
  logic          agg_bg, vic_bg;
  logic          cmp_mis, halt, grid_end;

  // ---------------------------------------------------------------------------
  // Address walkers: one for rows, one shared by background columns and victim
  // columns, one for toggle repetitions.
  // ---------------------------------------------------------------------------
  cbx_step_ctr #(.LIMIT(ROWS)) u_row_ctr (
    .clk(clk), .rst(rst), .clr(ctr_clr), .inc(row_inc), .q(row_q), .last(row_last)
  );

  cbx_step_ctr #(.LIMIT(COLS)) u_col_ctr (
    .clk(clk), .rst(rst), .clr(ctr_clr), .inc(col_inc), .q(col_q), .last(col_last)
  );

  cbx_step_ctr #(.LIMIT(TOGGLES)) u_tog_ctr (
    .clk(clk), .rst(rst), .clr(ctr_clr), .inc(tog_inc), .q(tog_q), .last(tog_last)
  );

  // ---------------------------------------------------------------------------
  // Neighbour selection and pattern values
  // ---------------------------------------------------------------------------
  assign has_right = !col_last;
  assign has_left  = (col_q != '0);
  assign agg_col   = side ? (col_q + CW'(1)) : (col_q - CW'(1));
  assign agg_bg    = bg_bit(row_q[0], agg_col[0], pol);
  assign vic_bg    = bg_bit(row_q[0], col_q[0], pol);
  assign cmp_mis   = (state == ST_CMP) && (mem_rdata != vic_bg);
  assign halt      = cmp_mis && stop_on_fail;
  assign grid_end  = row_last && col_last;

  always_comb begin
    ctr_clr = 1'b0;
    row_inc = 1'b0;
    col_inc = 1'b0;
    tog_inc = 1'b0;
    unique case (state)
      ST_IDLE: ctr_clr = start;
      ST_BG: begin
        col_inc = 1'b1;
        row_inc = col_last;
      end
      ST_RST:  tog_inc = !((side == 1'b0) && has_right);
      ST_CMP: begin
        if (!halt) begin
          row_inc = 1'b1;
          col_inc = row_last;
        end
      end
      default: ;
    endcase
  end

  // ---------------------------------------------------------------------------
  // Sequencer with registered memory commands
  // ---------------------------------------------------------------------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pol       <= 1'b0;
      side      <= 1'b0;
      mem_row   <= '0;
      mem_col   <= '0;
      mem_wdata <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      done      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_BG;
            pol   <= 1'b0;
            done  <= 1'b0;
          end
        end
        ST_BG: begin
          mem_row   <= row_q;
          mem_col   <= col_q;
          mem_wdata <= vic_bg;
          mem_we    <= 1'b1;
          if (grid_end) begin
            state <= ST_INV;
            side  <= 1'b1;          // column 0 has only a right neighbour
          end
        end
        ST_INV: begin
          mem_row   <= row_q;
          mem_col   <= agg_col;
          mem_wdata <= ~agg_bg;
          mem_we    <= 1'b1;
          state     <= ST_RST;
        end
        ST_RST: begin
          mem_row   <= row_q;
          mem_col   <= agg_col;
          mem_wdata <= agg_bg;
          mem_we    <= 1'b1;
          if ((side == 1'b0) && has_right) begin
            side  <= 1'b1;
            state <= ST_INV;
          end else if (!tog_last) begin
            side  <= has_left ? 1'b0 : 1'b1;
            state <= ST_INV;
          end else begin
            state <= ST_RDI;
          end
        end
        ST_RDI: begin
          mem_row <= row_q;
          mem_col <= col_q;
          mem_re  <= 1'b1;
          state   <= ST_RDW;
        end
        ST_RDW: state <= ST_CMP;
        ST_CMP: begin
          if (halt) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (grid_end) begin
            if (!pol) begin
              pol   <= 1'b1;
              state <= ST_BG;
            end else begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end else begin
            side  <= (row_last || has_left) ? 1'b0 : 1'b1;
            state <= ST_INV;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------------------------------------------------------------------
  // First-mismatch capture
  // ---------------------------------------------------------------------------
  cbx_fail_log #(.RW(RW), .CW(CW)) u_fail_log (
    .clk(clk), .rst(rst),
    .clr((state == ST_IDLE) && start),
    .hit(cmp_mis), .hit_row(row_q), .hit_col(col_q),
    .fail(fail), .fail_row(fail_row), .fail_col(fail_col)
  );

  // ---------------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------------
  logic [CW:0] col_x, mcol_x;
  assign col_x  = {1'b0, col_q};
  assign mcol_x = {1'b0, mem_col};

  assert_no_idle_access_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> (!mem_we && !mem_re));

  assert_victim_untouched_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_INV || $past(state) == ST_RST) |-> (mem_we && mem_col != col_q));

  assert_neighbour_only_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_INV) |-> ((mcol_x == col_x + CWX'(1)) || (mcol_x + CWX'(1) == col_x)));

  assert_reps_wrapped_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDI) |-> (tog_q == '0));

  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  assert_halt_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_mis && stop_on_fail) |=> (done && fail && state == ST_IDLE));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !(state == ST_IDLE && start)) |=> done);

endmodule

// File: tb/tb_cbx_xtalk_bist.sv
module tb_cbx_xtalk_bist;
  localparam int ROWS       = 8;
  localparam int COLS       = 8;
  localparam int TOGGLES    = 2;
  localparam int CLK_PERIOD = 10;
  localparam int MAXOPS     = 4096;
  localparam int RW         = $clog2(ROWS);
  localparam int CW         = $clog2(COLS);

  logic          clk, rst, start, stop_on_fail;
  logic [RW-1:0] mem_row, fail_row;
  logic [CW-1:0] mem_col, fail_col;
  logic          mem_wdata, mem_we, mem_re, mem_rdata, done, fail;

  cbx_xtalk_bist #(.ROWS(ROWS), .COLS(COLS), .TOGGLES(TOGGLES)) dut (
    .clk(clk), .rst(rst), .start(start), .stop_on_fail(stop_on_fail),
    .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .fail_row(fail_row), .fail_col(fail_col)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference access sequence ----------------
  int exp_kind [MAXOPS];   // 1 background, 2 interior toggle, 4 edge toggle, 3 read
  int exp_code [MAXOPS];
  int exp_pol  [MAXOPS];
  int exp_row  [MAXOPS];
  int exp_col  [MAXOPS];
  int n_ops;

  function automatic int bgv(input int r, input int c, input int p);
    return (r ^ c ^ p) & 1;
  endfunction

  function automatic int enc(input int re, input int we, input int wd, input int r, input int c);
    return (re << 12) | (we << 11) | (wd << 10) | (r << 5) | c;
  endfunction

  task automatic push(input int kind, input int code, input int p, input int r, input int c);
    exp_kind[n_ops] = kind;
    exp_code[n_ops] = code;
    exp_pol[n_ops]  = p;
    exp_row[n_ops]  = r;
    exp_col[n_ops]  = c;
    n_ops++;
  endtask

  task automatic build_ref();
    n_ops = 0;
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          push(1, enc(0, 1, bgv(r, c, p), r, c), p, r, c);
      for (int v = 0; v < COLS; v++) begin
        for (int r = 0; r < ROWS; r++) begin
          for (int t = 0; t < TOGGLES; t++) begin
            int k;
            k = (v == 0 || v == COLS - 1) ? 4 : 2;
            if (v > 0) begin
              push(k, enc(0, 1, 1 - bgv(r, v - 1, p), r, v - 1), p, r, v);
              push(k, enc(0, 1, bgv(r, v - 1, p), r, v - 1), p, r, v);
            end
            if (v < COLS - 1) begin
              push(k, enc(0, 1, 1 - bgv(r, v + 1, p), r, v + 1), p, r, v);
              push(k, enc(0, 1, bgv(r, v + 1, p), r, v + 1), p, r, v);
            end
          end
          push(3, enc(1, 0, 0, r, v), p, r, v);
        end
      end
    end
  endtask

  function automatic int read_index(input int p, input int r, input int c);
    for (int i = 0; i < n_ops; i++)
      if (exp_kind[i] == 3 && exp_pol[i] == p && exp_row[i] == r && exp_col[i] == c)
        return i;
    return -1;
  endfunction

  // ---------------- memory model with coupling faults ----------------
  bit f_en [2];
  int f_vr [2];
  int f_vc [2];
  int f_ac [2];
  bit mem_arr [ROWS][COLS];

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem_arr[r][c] = 1'b0;
      mem_rdata <= 1'b0;
    end else begin
      if (mem_we) begin
        for (int f = 0; f < 2; f++)
          if (f_en[f] && int'(mem_row) == f_vr[f] && int'(mem_col) == f_ac[f] &&
              !mem_arr[mem_row][mem_col] && mem_wdata)
            mem_arr[f_vr[f]][f_vc[f]] = 1'b1;
        mem_arr[mem_row][mem_col] = mem_wdata;
      end
      mem_rdata <= mem_arr[mem_row][mem_col];
    end
  end

  // ---------------- access monitor ----------------
  int op_idx = 0;
  bit mon_en = 1'b0;

  always @(negedge clk) begin
    if (mon_en && !rst && (mem_we || mem_re)) begin
      if (op_idx >= n_ops) begin
        check(1'b0, "R8", "access beyond end of sequence", op_idx, n_ops);
      end else begin
        int act;
        string rq;
        act = enc(int'(mem_re), int'(mem_we), mem_re ? 0 : int'(mem_wdata),
                  int'(mem_row), int'(mem_col));
        case (exp_kind[op_idx])
          1: rq = "R2";
          2: rq = "R3";
          4: rq = "R4";
          default: rq = "R5";
        endcase
        check(act == exp_code[op_idx], rq, "access code", act, exp_code[op_idx]);
      end
      op_idx++;
    end
  end

  // ---------------- watchdog ----------------
  int cyc_total = 0;
  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual %0d cycles expected below 150000", cyc_total);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- one run ----------------
  task automatic run_test(input bit stop, input int exp_ops, input bit exp_fail,
                          input int exp_fr, input int exp_fc);
    int cyc;
    @(negedge clk);
    stop_on_fail = stop;
    op_idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && fail == 1'b0, "R10", "done/fail cleared by start",
          int'({done, fail}), 0);
    check(mem_we == 1'b0, "R1", "no write yet", int'(mem_we), 0);
    @(negedge clk);
    check(mem_we && mem_row == '0 && mem_col == '0 && mem_wdata == 1'b0, "R1",
          "first write at cell 0,0 with 0",
          enc(0, int'(mem_we), int'(mem_wdata), int'(mem_row), int'(mem_col)),
          enc(0, 1, 0, 0, 0));
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, "R9", "done reached", int'(done), 1);
    check(op_idx == exp_ops, stop ? "R7" : "R8", "access count", op_idx, exp_ops);
    check(fail == exp_fail, exp_fail ? "R6" : "R9", "fail flag", int'(fail), int'(exp_fail));
    if (exp_fail) begin
      check(int'(fail_row) == exp_fr, "R6", "fail row", int'(fail_row), exp_fr);
      check(int'(fail_col) == exp_fc, "R6", "fail col", int'(fail_col), exp_fc);
    end
    repeat (6) @(negedge clk);
    check(done == 1'b1 && op_idx == exp_ops, "R9", "idle after done holds",
          op_idx, exp_ops);
  endtask

  // fault helper: victim (vr,vc), neighbour column ac in the same row
  task automatic set_fault(input int f, input bit en, input int vr, input int vc, input int ac);
    f_en[f] = en;
    f_vr[f] = vr;
    f_vc[f] = vc;
    f_ac[f] = ac;
  endtask

  function automatic int det_pol(input int r, input int c);
    return (r ^ c) & 1;   // polarity in which the victim holds 0
  endfunction

  initial begin
    rst = 1'b1;
    start = 1'b0;
    stop_on_fail = 1'b0;
    set_fault(0, 1'b0, 0, 0, 0);
    set_fault(1, 1'b0, 0, 0, 0);
    void'($urandom(32'd20240611));
    build_ref();
    repeat (3) @(negedge clk);
    check(!done && !fail && !mem_we && !mem_re, "R1", "reset state",
          int'({done, fail, mem_we, mem_re}), 0);
    rst = 1'b0;
    mon_en = 1'b1;
    repeat (3) @(negedge clk);
    check(!mem_we && !mem_re, "R1", "idle issues nothing", int'({mem_we, mem_re}), 0);

    // clean memory, full run (R2 R3 R4 R5 via monitor, R8 R9)
    run_test(1'b0, n_ops, 1'b0, 0, 0);

    // left edge victim, stop at first miss (R4 R7)
    set_fault(0, 1'b1, 0, 0, 1);
    run_test(1'b1, read_index(det_pol(0, 0), 0, 0) + 1, 1'b1, 0, 0);

    // right edge victim, continue (R4 R8)
    set_fault(0, 1'b1, ROWS - 1, COLS - 1, COLS - 2);
    run_test(1'b0, n_ops, 1'b1, ROWS - 1, COLS - 1);

    // victim seen only in polarity 1, stop (R2 R7)
    set_fault(0, 1'b1, 0, 1, 2);
    run_test(1'b1, read_index(1, 0, 1) + 1, 1'b1, 0, 1);

    // two faults, first one kept (R6)
    set_fault(0, 1'b1, 2, 3, 2);   // shows in polarity 1
    set_fault(1, 1'b1, 5, 1, 0);   // shows in polarity 0, found first
    run_test(1'b0, n_ops, 1'b1, 5, 1);

    // new start after failing run clears results (R10)
    set_fault(0, 1'b0, 0, 0, 0);
    set_fault(1, 1'b0, 0, 0, 0);
    run_test(1'b0, n_ops, 1'b0, 0, 0);

    // random single faults
    for (int k = 0; k < 6; k++) begin
      int vr, vc, ac;
      bit st;
      vr = int'($urandom_range(ROWS - 1));
      vc = int'($urandom_range(COLS - 1));
      if (vc == 0) ac = 1;
      else if (vc == COLS - 1) ac = COLS - 2;
      else ac = ($urandom_range(1) == 1) ? vc + 1 : vc - 1;
      st = bit'($urandom_range(1));
      set_fault(0, 1'b1, vr, vc, ac);
      run_test(st, st ? read_index(det_pol(vr, vc), vr, vc) + 1 : n_ops, 1'b1, vr, vc);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule